// File: doc/BRIEF.md
# External Data Memory Router with EEPROM Page Write Buffer

This block sits on the external-data move path of an 8-bit microcontroller. Every access carries a 16-bit address, and the block sends it to one of three regions: the on-chip expanded RAM, an on-chip data EEPROM, or external data memory. Two configuration bits choose the route. The block drives a strobe-qualified select line for each region. It serves EEPROM reads itself, from a cell array that is modelled as a plain RAM.

EEPROM writes first pass a three-way permission check. A write that passes lands in a 32-slot page buffer, and each slot carries its own valid bit. In load-only mode a write just fills its slot. A write made outside load-only mode also starts a programming cycle. The sequencer walks the buffer and copies every filled slot into its place in the page, the page being the one the starting write addressed. It then holds the cell busy for a programmable number of cycles. While programming runs, the ready status bit reads 0, and a read of any location in the page being programmed returns that byte with its top bit inverted. Software uses this inverted read-back to poll for completion.

A write that fails the permission check is dropped. It raises a fault flag that stays set until the fault-clear input is pulsed.

Top module: `xdata_ee_pager`

## Requirements
- R1: When `cfg_xram_off` is 0 and the address is below `XRAM_SIZE` (256), an access (either strobe high) asserts `sel_xram` only. The expanded RAM takes priority over the EEPROM.
- R2: Any other address below `EE_SIZE` (512) asserts `sel_eeprom` when `cfg_ee_en` is 1. Every remaining access asserts `sel_xmem`. No select is high when both strobes are low, and at most one select is ever high.
- R3: An EEPROM-region write is accepted only when `ctl_wr_en`, `ee_ready` and `ctl_wr_ok` are all 1. Any other such write is dropped: buffer and array are unchanged, and `fault` is 1 on the next cycle.
- R4: `fault` stays set until `fault_clr` is sampled high. A bad write in the same cycle as `fault_clr` keeps `fault` set.
- R5: With `ctl_load_only` at 1, an accepted write stores the byte in buffer slot `addr[4:0]` only. The array does not change and `ee_ready` stays 1.
- R6: An accepted write with `ctl_load_only` at 0 stores its byte and then programs every filled slot into the page whose base is `addr` with bits 4..0 cleared. Array bytes of unfilled slots keep their old value.
- R7: `ee_ready` is 0 on the cycle after a programming write. It returns to 1 exactly 32 + max(`prog_cycles`, 1) clock edges after that write's edge.
- R8: While `ee_ready` is 0, a read of a location being programmed returns the new byte with bit 7 inverted. A read of any other location returns the array contents.
- R9: When programming finishes, the buffer is empty. A later programming write commits only the slots filled since then.
- R10: An EEPROM-region read updates `rdata` on the clock edge at which `rd_en` is sampled. Reads of the other regions leave `rdata` unchanged.
- R11: After reset, `ee_ready` is 1, `fault` is 0, `rdata` is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| cfg_xram_off | input | 1 | 1 disables the expanded-RAM window |
| cfg_ee_en | input | 1 | 1 maps the EEPROM into the data space |
| ctl_wr_en | input | 1 | EEPROM write enable |
| ctl_wr_ok | input | 1 | Write-inhibit release (1 allows writes) |
| ctl_load_only | input | 1 | 1 makes writes only fill the page buffer |
| prog_cycles | input | 16 | Programming wait after the page walk, in cycles |
| fault_clr | input | 1 | Clears the sticky fault flag |
| rdata | output | 8 | EEPROM read data |
| ee_ready | output | 1 | Ready/busy status, 0 while programming |
| fault | output | 1 | Sticky rejected-write flag |
| sel_xram | output | 1 | Expanded RAM selected |
| sel_eeprom | output | 1 | EEPROM selected |
| sel_xmem | output | 1 | External data memory selected |

## Verification
Several rules are checked on every cycle: that the selects are one-hot and follow the expanded-RAM priority, that a write made while busy raises the fault, that the fault stays set, that a programming write drops ready while a load-only write keeps it, and that `rdata` holds outside EEPROM reads. Some behaviour shows only in the directed scenarios: which bytes reach the array after a mix of loads and commits, the exact length of the busy window for different wait settings, the inverted read-back during programming, and that the buffer is empty after a page completes.

// File: rtl/eepb_pkg.sv
package eepb_pkg;
  typedef enum logic [1:0] {
    RGN_XRAM   = 2'd0,
    RGN_EEPROM = 2'd1,
    RGN_XMEM   = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WALK = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/eepb_region_dec.sv
module eepb_region_dec
  import eepb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int XRAM_SIZE = 256,
  parameter int EE_SIZE   = 512
) (
  input  logic [AW-1:0] addr,
  input  logic          cfg_xram_off,
  input  logic          cfg_ee_en,
  output region_e       region
);
  localparam logic [AW:0] XRAM_LIM = (AW+1)'(XRAM_SIZE);
  localparam logic [AW:0] EE_LIM   = (AW+1)'(EE_SIZE);

  logic below_xram;
  logic below_ee;

  always_comb begin
    below_xram = ({1'b0, addr} < XRAM_LIM);
    below_ee   = ({1'b0, addr} < EE_LIM);
    if (below_xram && !cfg_xram_off) begin
      region = RGN_XRAM;
    end else if (below_ee && cfg_ee_en) begin
      region = RGN_EEPROM;
    end else begin
      region = RGN_XMEM;
    end
  end
endmodule

// File: rtl/eepb_page_buf.sv
module eepb_page_buf #(
  parameter int DW    = 8,
  parameter int SLOTS = 32,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_slot,
  input  logic [DW-1:0]    wr_data,
  input  logic             clr_all,
  input  logic [SW-1:0]    rd_slot_a,
  input  logic [SW-1:0]    rd_slot_b,
  output logic [SLOTS-1:0] vld,
  output logic [DW-1:0]    dat_a,
  output logic [DW-1:0]    dat_b
);
  logic [SLOTS-1:0][DW-1:0] dat_q;
  logic [SLOTS-1:0][DW-1:0] dat_d;
  logic [SLOTS-1:0]         vld_q;
  logic [SLOTS-1:0]         vld_d;

  always_comb begin
    dat_d = dat_q;
    vld_d = vld_q;
    if (clr_all) begin
      vld_d = '0;
    end
    if (wr_en) begin
      dat_d[wr_slot] = wr_data;
      vld_d[wr_slot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= '0;
    end else begin
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign vld   = vld_q;
  assign dat_a = dat_q[rd_slot_a];
  assign dat_b = dat_q[rd_slot_b];
endmodule

// File: rtl/eepb_prog_seq.sv
module eepb_prog_seq
  import eepb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SLOTS = 32,
  parameter int TW    = 16,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [AW-1:0]    commit_base,
  input  logic [SLOTS-1:0] commit_mask,
  input  logic [TW-1:0]    prog_cycles,
  output logic             ready,
  output logic             walk_we,
  output logic [SW-1:0]    walk_slot,
  output logic [AW-1:0]    prog_base,
  output logic [SLOTS-1:0] prog_mask,
  output logic             done
);
  seq_state_e       st_q,   st_d;
  logic [SW-1:0]    slot_q, slot_d;
  logic [TW-1:0]    tmr_q,  tmr_d;
  logic [AW-1:0]    base_q, base_d;
  logic [SLOTS-1:0] mask_q, mask_d;
  logic             tmr_end;

  assign tmr_end = (tmr_q <= TW'(1));

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    tmr_d  = tmr_q;
    base_d = base_q;
    mask_d = mask_q;
    case (st_q)
      SEQ_IDLE: begin
        if (commit) begin
          st_d   = SEQ_WALK;
          slot_d = '0;
          base_d = commit_base;
          mask_d = commit_mask;
        end
      end
      SEQ_WALK: begin
        if (slot_q == SW'(SLOTS-1)) begin
          st_d  = SEQ_WAIT;
          tmr_d = prog_cycles;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (tmr_end) begin
          st_d   = SEQ_IDLE;
          mask_d = '0;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      slot_q <= '0;
      tmr_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      tmr_q  <= tmr_d;
      base_q <= base_d;
      mask_q <= mask_d;
    end
  end

  assign ready     = (st_q == SEQ_IDLE);
  assign walk_we   = (st_q == SEQ_WALK) && mask_q[slot_q];
  assign walk_slot = slot_q;
  assign prog_base = base_q;
  assign prog_mask = mask_q;
  assign done      = (st_q == SEQ_WAIT) && tmr_end;
endmodule

// File: rtl/eepb_cell_ram.sv
module eepb_cell_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  localparam int RAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xdata_ee_pager.sv
module xdata_ee_pager
  import eepb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int XRAM_SIZE = 256,
  parameter int EE_SIZE   = 512,
  parameter int SLOTS     = 32,
  parameter int TW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          cfg_xram_off,
  input  logic          cfg_ee_en,
  input  logic          ctl_wr_en,
  input  logic          ctl_wr_ok,
  input  logic          ctl_load_only,
  input  logic [TW-1:0] prog_cycles,
  input  logic          fault_clr,
  output logic [DW-1:0] rdata,
  output logic          ee_ready,
  output logic          fault,
  output logic          sel_xram,
  output logic          sel_eeprom,
  output logic          sel_xmem
);
  localparam int SW    = $clog2(SLOTS);
  localparam int EE_AW = $clog2(EE_SIZE);

  region_e          region;
  logic             access;
  logic             ee_wr;
  logic             wr_permit;
  logic             accept;
  logic             reject;
  logic             commit;
  logic [SW-1:0]    slot;
  logic [AW-1:0]    page_base;
  logic [SLOTS-1:0] slot_bit;
  logic [SLOTS-1:0] buf_vld;
  logic [DW-1:0]    buf_walk_dat;
  logic [DW-1:0]    buf_rd_dat;
  logic             walk_we;
  logic [SW-1:0]    walk_slot;
  logic [AW-1:0]    prog_base;
  logic [SLOTS-1:0] prog_mask;
  logic             prog_done;
  logic [EE_AW-1:0] ram_waddr;
  logic [DW-1:0]    ram_rd;
  logic             poll_hit;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             fault_q, fault_d;

  eepb_region_dec #(
    .AW(AW), .XRAM_SIZE(XRAM_SIZE), .EE_SIZE(EE_SIZE)
  ) u_dec (
    .addr(addr), .cfg_xram_off(cfg_xram_off), .cfg_ee_en(cfg_ee_en), .region(region)
  );

  always_comb begin
    access     = rd_en || wr_en;
    sel_xram   = access && (region == RGN_XRAM);
    sel_eeprom = access && (region == RGN_EEPROM);
    sel_xmem   = access && (region == RGN_XMEM);
    slot       = addr[SW-1:0];
    page_base  = {addr[AW-1:SW], {SW{1'b0}}};
    slot_bit   = SLOTS'(1) << slot;
    ee_wr      = wr_en && (region == RGN_EEPROM);
    wr_permit  = ctl_wr_en && ee_ready && ctl_wr_ok;
    accept     = ee_wr && wr_permit;
    reject     = ee_wr && !wr_permit;
    commit     = accept && !ctl_load_only;
  end

  eepb_page_buf #(.DW(DW), .SLOTS(SLOTS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept), .wr_slot(slot), .wr_data(wdata),
    .clr_all(prog_done),
    .rd_slot_a(walk_slot), .rd_slot_b(slot),
    .vld(buf_vld), .dat_a(buf_walk_dat), .dat_b(buf_rd_dat)
  );

  eepb_prog_seq #(.AW(AW), .SLOTS(SLOTS), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .commit_base(page_base), .commit_mask(buf_vld | slot_bit),
    .prog_cycles(prog_cycles),
    .ready(ee_ready), .walk_we(walk_we), .walk_slot(walk_slot),
    .prog_base(prog_base), .prog_mask(prog_mask), .done(prog_done)
  );

  assign ram_waddr = {prog_base[EE_AW-1:SW], walk_slot};

  eepb_cell_ram #(.DW(DW), .DEPTH(EE_SIZE)) u_ram (
    .clk(clk), .we(walk_we), .waddr(ram_waddr), .wdata(buf_walk_dat),
    .raddr(addr[EE_AW-1:0]), .rdata(ram_rd)
  );

  always_comb begin
    poll_hit = !ee_ready && (addr[AW-1:SW] == prog_base[AW-1:SW]) && prog_mask[slot];
    rdata_d  = rdata_q;
    if (rd_en && (region == RGN_EEPROM)) begin
      rdata_d = poll_hit ? {~buf_rd_dat[DW-1], buf_rd_dat[DW-2:0]} : ram_rd;
    end
    fault_d = fault_q;
    if (reject) begin
      fault_d = 1'b1;
    end else if (fault_clr) begin
      fault_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      fault_q <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      fault_q <= fault_d;
    end
  end

  assign rdata = rdata_q;
  assign fault = fault_q;
endmodule

// File: rtl/eepb_chk.sv
module eepb_chk #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int XRAM_SIZE = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic          wr_en,
  input logic          cfg_xram_off,
  input logic          ctl_wr_en,
  input logic          ctl_wr_ok,
  input logic          ctl_load_only,
  input logic          fault_clr,
  input logic [DW-1:0] rdata,
  input logic          ee_ready,
  input logic          fault,
  input logic          sel_xram,
  input logic          sel_eeprom,
  input logic          sel_xmem
);
  localparam logic [AW:0] XLIM = (AW+1)'(XRAM_SIZE);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_xram, sel_eeprom, sel_xmem}));

  // R1
  xram_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !cfg_xram_off && ({1'b0, addr} < XLIM)) |-> sel_xram);

  // R3
  busy_write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_eeprom && !ee_ready) |=> fault);

  // R4
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  // R7
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_eeprom && ee_ready && ctl_wr_en && ctl_wr_ok && !ctl_load_only) |=> !ee_ready);

  // R5
  load_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_eeprom && ee_ready && ctl_wr_en && ctl_wr_ok && ctl_load_only) |=> ee_ready);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && sel_eeprom) |=> $stable(rdata));
endmodule

bind xdata_ee_pager eepb_chk #(.AW(AW), .DW(DW), .XRAM_SIZE(XRAM_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .cfg_xram_off(cfg_xram_off), .ctl_wr_en(ctl_wr_en), .ctl_wr_ok(ctl_wr_ok),
  .ctl_load_only(ctl_load_only), .fault_clr(fault_clr), .rdata(rdata),
  .ee_ready(ee_ready), .fault(fault), .sel_xram(sel_xram),
  .sel_eeprom(sel_eeprom), .sel_xmem(sel_xmem)
);

// File: tb/sim_xdata_ee_pager.sv
`timescale 1ns/1ps
module sim_xdata_ee_pager;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_en, wr_en;
  logic        cfg_xram_off, cfg_ee_en;
  logic        ctl_wr_en, ctl_wr_ok, ctl_load_only;
  logic [15:0] prog_cycles;
  logic        fault_clr;
  logic [7:0]  rdata;
  logic        ee_ready, fault;
  logic        sel_xram, sel_eeprom, sel_xmem;

  int checks;
  int failures;

  xdata_ee_pager u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
    .cfg_xram_off(cfg_xram_off), .cfg_ee_en(cfg_ee_en), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_ok(ctl_wr_ok), .ctl_load_only(ctl_load_only), .prog_cycles(prog_cycles),
    .fault_clr(fault_clr), .rdata(rdata), .ee_ready(ee_ready), .fault(fault),
    .sel_xram(sel_xram), .sel_eeprom(sel_eeprom), .sel_xmem(sel_xmem)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // counts edges from the last write edge until ee_ready is back
  task automatic wait_ready(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (ee_ready) break;
    end
  endtask

  task automatic commit_wait(input logic [15:0] a, input logic [7:0] d);
    int n;
    wr(a, d);
    wait_ready(n);
  endtask

  task automatic t_reset;
    chk("R11 ready", ee_ready, 1);
    chk("R11 fault", fault, 0);
    chk("R11 rdata", rdata, 0);
  endtask

  task automatic t_decode;
    @(negedge clk);
    addr = 16'h0010; rd_en = 1'b0; #1;
    chk("R2 no strobe", {sel_xram, sel_eeprom, sel_xmem}, 3'b000);
    rd_en = 1'b1; #1;
    chk("R1 xram window", {sel_xram, sel_eeprom, sel_xmem}, 3'b100);
    cfg_xram_off = 1'b1; #1;
    chk("R2 eeprom low", {sel_xram, sel_eeprom, sel_xmem}, 3'b010);
    cfg_ee_en = 1'b0; #1;
    chk("R2 xmem when ee off", {sel_xram, sel_eeprom, sel_xmem}, 3'b001);
    cfg_ee_en = 1'b1; cfg_xram_off = 1'b0; addr = 16'h0150; #1;
    chk("R2 eeprom range", {sel_xram, sel_eeprom, sel_xmem}, 3'b010);
    addr = 16'h0300; #1;
    chk("R2 above eeprom", {sel_xram, sel_eeprom, sel_xmem}, 3'b001);
    rd_en = 1'b0;
  endtask

  task automatic t_program;
    int n;
    logic [7:0] d;
    prog_cycles = 16'd20;
    wr(16'h0143, 8'h11);
    chk("R7 busy after commit", ee_ready, 0);
    wait_ready(n);
    chk("R7 busy length", n, 52);
    rd(16'h0143, d);
    chk("R6 single byte", d, 8'h11);
    commit_wait(16'h0104, 8'h44);
    commit_wait(16'h0103, 8'h5A);
    commit_wait(16'h0161, 8'h61);
  endtask

  task automatic t_load_commit;
    int n;
    logic [7:0] d;
    ctl_load_only = 1'b1;
    wr(16'h0103, 8'hAA);
    chk("R5 ready kept", ee_ready, 1);
    rd(16'h0103, d);
    chk("R5 array untouched", d, 8'h5A);
    ctl_load_only = 1'b0;
    wr(16'h0105, 8'hBB);
    rd(16'h0105, d);
    chk("R8 poll committing byte", d, 8'h3B);
    rd(16'h0103, d);
    chk("R8 poll loaded byte", d, 8'h2A);
    rd(16'h0104, d);
    chk("R8 non-member reads array", d, 8'h44);
    wait_ready(n);
    rd(16'h0103, d);
    chk("R6 loaded slot", d, 8'hAA);
    rd(16'h0105, d);
    chk("R6 committing slot", d, 8'hBB);
    rd(16'h0104, d);
    chk("R6 unfilled slot kept", d, 8'h44);
  endtask

  task automatic t_buffer_empty;
    logic [7:0] d;
    commit_wait(16'h0140, 8'h22);
    rd(16'h0143, d);
    chk("R9 old slot not replayed", d, 8'h11);
    rd(16'h0140, d);
    chk("R9 new byte", d, 8'h22);
  endtask

  task automatic t_fault;
    int n;
    logic [7:0] d;
    ctl_wr_en = 1'b0;
    wr(16'h0150, 8'h77);
    chk("R3 fault on disabled", fault, 1);
    chk("R3 no programming", ee_ready, 1);
    ctl_wr_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 sticky", fault, 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk("R4 cleared", fault, 0);
    ctl_wr_ok = 1'b0;
    wr(16'h0150, 8'h77);
    chk("R3 fault on inhibit", fault, 1);
    ctl_wr_ok = 1'b1;
    @(negedge clk);
    addr = 16'h0150; wdata = 8'h00; wr_en = 1'b1; ctl_wr_en = 1'b0; fault_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ctl_wr_en = 1'b1; fault_clr = 1'b0;
    chk("R4 set beats clear", fault, 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    wr(16'h0160, 8'h01);
    wr(16'h0161, 8'h99);
    chk("R3 fault when busy", fault, 1);
    wait_ready(n);
    rd(16'h0161, d);
    chk("R3 busy write dropped", d, 8'h61);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
  endtask

  task automatic t_short_wait;
    int n;
    prog_cycles = 16'd0;
    wr(16'h0170, 8'h70);
    wait_ready(n);
    chk("R7 zero wait length", n, 33);
    prog_cycles = 16'd20;
  endtask

  task automatic t_other_reads;
    logic [7:0] d, prev;
    rd(16'h0170, prev);
    chk("R10 eeprom read", prev, 8'h70);
    rd(16'h0010, d);
    chk("R10 xram read holds", d, prev);
    rd(16'h0400, d);
    chk("R10 xmem read holds", d, prev);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
    cfg_xram_off = 1'b0; cfg_ee_en = 1'b1; ctl_wr_en = 1'b1; ctl_wr_ok = 1'b1;
    ctl_load_only = 1'b0; prog_cycles = 16'd20; fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_program();
    t_load_commit();
    t_buffer_empty();
    t_fault();
    t_short_wait();
    t_other_reads();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule